// File: doc/BRIEF.md
# Receive Label Filter Memory

This block holds a small table of 8-bit labels for each serial avionics receiver and uses it to decide which incoming 32-bit words are passed on. A host fills the table by issuing a run of load strobes and can read it back by issuing a run of read strobes. Neither operation uses an address. A rising transition of the sequence bit in a small control register opens the run, and an internal pointer steps through the entries one strobe at a time.

While the sequence bit is clear, each decoded word offered by a receiver is checked against that receiver's table. If that receiver's filter is off, every word is forwarded. If the filter is on, a word is forwarded only when its low label byte equals one of the stored entries. A word that is not forwarded leaves no trace at the outputs. While the sequence bit is set, reception is suspended and offered words are dropped. Each receiver has its own table, its own load and read strobes, and its own filter enable.

Top module: `label_filter_top`

## Requirements
- R1: After reset every table entry of every receiver holds 0x00, both filters are off, the sequence bit is clear, and `rd_valid` and `acc_stb` are low.
- R2: A control write with bit 0 set while the sequence bit is clear zeroes the pointer of every receiver. Writing bit 0 as 1 while it is already 1 leaves the pointers where they are.
- R3: While the sequence bit is set, each `lbl_wr[i]` strobe stores `host_wdata` into entry `ptr` of receiver i and advances the pointer. Once 16 accesses have been made, further strobes change nothing.
- R4: While the sequence bit is set, each `lbl_rd[i]` strobe returns entry `ptr` of receiver i on `rd_data`, with `rd_valid` high on the cycle after the strobe, and advances the pointer. Entries come out in load order, and nothing is returned after 16 accesses.
- R5: Load and read strobes given while the sequence bit is clear have no effect on the tables and produce no `rd_valid`.
- R6: While the sequence bit is set, words offered on `rx_valid` produce no `acc_stb`.
- R7: With the sequence bit clear and filter i off (control bit i+1 = 0), every word offered to receiver i appears on `acc_word` with `acc_stb[i]` high one cycle later.
- R8: With filter i on, a word is forwarded only if its bits [7:0] equal some stored entry of receiver i. Otherwise no `acc_stb[i]` is raised.
- R9: The compared label is always word bits [7:0], and the upper bits play no part. The value 0x00 is an ordinary label, so the reset table accepts label 0x00.
- R10: Each receiver's strobes touch only its own table and pointer. Filter bit i+1 governs only receiver i.
- R11: A load strobe and a read strobe on the same receiver in the same cycle perform the load only. When read strobes for several receivers coincide, only the lowest-numbered receiver is served, and the others are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | N_RX+1 | Bit 0 sequence bit, bit i+1 filter enable of receiver i |
| host_wdata | input | 8 | Label byte for load strobes |
| lbl_wr | input | N_RX | Per-receiver label load strobe |
| lbl_rd | input | N_RX | Per-receiver label read strobe |
| rd_valid | output | 1 | Read-back byte valid |
| rd_data | output | 8 | Read-back label byte |
| rx_valid | input | N_RX | Per-receiver word offered |
| rx_word | input | 32*N_RX | Offered words, receiver i at bits [32i+31:32i] |
| acc_stb | output | N_RX | Per-receiver word accepted |
| acc_word | output | 32*N_RX | Accepted words, same layout as `rx_word` |

## Verification
The bench builds the block with its defaults: two receivers and a 16-entry table. With 16 entries, the pointer can be driven past its limit, so the ignored 17th load and read can be observed. With two receivers, cross-receiver isolation and the lowest-index read priority can be tested. The loaded tables include 0x00 and vary the upper word bits, so the fixed label field and the ordinary treatment of zero are both tested through acceptance alone.

// File: rtl/lblf_pkg.sv
package lblf_pkg;

    localparam int LBL_W  = 8;
    localparam int WORD_W = 32;

    typedef logic [LBL_W-1:0]  label_t;
    typedef logic [WORD_W-1:0] word_t;

    // host access request seen by one table
    typedef struct packed {
        logic   wr;
        logic   rd;
        label_t data;
    } hreq_t;

    // label field position is fixed regardless of serial bit order
    function automatic label_t label_of(input word_t w);
        return w[LBL_W-1:0];
    endfunction

    // isolate lowest set bit of a strobe vector
    function automatic logic [15:0] lowest_bit(input logic [15:0] v);
        return v & (~v + 16'd1);
    endfunction

endpackage

// File: rtl/lblf_ctl.sv
module lblf_ctl
    import lblf_pkg::*;
#(
    parameter int N_RX = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [N_RX:0]   wdata,
    output logic            seq_on,
    output logic            seq_start,
    output logic [N_RX-1:0] flt_en
);

    logic            arm_q;
    logic [N_RX-1:0] flt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q <= 1'b0;
            flt_q <= '0;
        end else if (we) begin
            arm_q <= wdata[0];
            flt_q <= wdata[N_RX:1];
        end
    end

    // 0 -> 1 transition of the sequence bit, acts on the same edge
    assign seq_start = we & wdata[0] & ~arm_q;
    assign seq_on    = arm_q;
    assign flt_en    = flt_q;

endmodule

// File: rtl/lblf_bank.sv
module lblf_bank
    import lblf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   seq_on,
    input  logic                   seq_start,
    input  hreq_t                  req,
    output logic                   rd_hit,
    output label_t                 rd_byte,
    output logic [DEPTH*LBL_W-1:0] tbl_flat
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    label_t       mem [DEPTH];
    logic [PW:0]  ptr;
    logic         done;
    logic [PW-1:0] idx;
    logic         step;

    assign done    = (ptr == (PW+1)'(DEPTH));
    assign idx     = ptr[PW-1:0];
    assign step    = seq_on & ~done & (req.wr | req.rd);
    assign rd_hit  = seq_on & ~done & req.rd & ~req.wr;
    assign rd_byte = mem[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
        end else begin
            if (seq_start)
                ptr <= '0;
            else if (step)
                ptr <= ptr + 1'b1;
            if (seq_on && !done && req.wr)
                mem[idx] <= req.data;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign tbl_flat[g*LBL_W +: LBL_W] = mem[g];
    end

endmodule

// File: rtl/lblf_match.sv
module lblf_match
    import lblf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic [DEPTH*LBL_W-1:0] tbl_flat,
    input  label_t                 label,
    output logic                   hit
);

    logic [DEPTH-1:0] eq;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign eq[g] = (tbl_flat[g*LBL_W +: LBL_W] == label);
    end

    assign hit = |eq;

endmodule

// File: rtl/label_filter_top.sv
module label_filter_top
    import lblf_pkg::*;
#(
    parameter int N_RX  = 2,
    parameter int DEPTH = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ctl_we,
    input  logic [N_RX:0]          ctl_wdata,
    input  logic [LBL_W-1:0]       host_wdata,
    input  logic [N_RX-1:0]        lbl_wr,
    input  logic [N_RX-1:0]        lbl_rd,
    output logic                   rd_valid,
    output logic [LBL_W-1:0]       rd_data,
    input  logic [N_RX-1:0]        rx_valid,
    input  logic [N_RX*WORD_W-1:0] rx_word,
    output logic [N_RX-1:0]        acc_stb,
    output logic [N_RX*WORD_W-1:0] acc_word
);

    logic            seq_on;
    logic            seq_start;
    logic [N_RX-1:0] flt_en;
    logic [N_RX-1:0] rd_grant;
    logic [N_RX-1:0] rd_hit;
    logic [N_RX-1:0] hit;
    label_t          rbyte [N_RX];
    logic [15:0]     rd_low;

    lblf_ctl #(.N_RX(N_RX)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .we        (ctl_we),
        .wdata     (ctl_wdata),
        .seq_on    (seq_on),
        .seq_start (seq_start),
        .flt_en    (flt_en)
    );

    assign rd_low   = lowest_bit(16'(lbl_rd));
    assign rd_grant = rd_low[N_RX-1:0];

    for (genvar i = 0; i < N_RX; i++) begin : g_rx
        hreq_t                  req;
        logic [DEPTH*LBL_W-1:0] tbl;
        word_t                  w;

        assign req.wr   = lbl_wr[i];
        assign req.rd   = rd_grant[i];
        assign req.data = host_wdata;
        assign w        = rx_word[i*WORD_W +: WORD_W];

        lblf_bank #(.DEPTH(DEPTH)) u_bank (
            .clk       (clk),
            .rst       (rst),
            .seq_on    (seq_on),
            .seq_start (seq_start),
            .req       (req),
            .rd_hit    (rd_hit[i]),
            .rd_byte   (rbyte[i]),
            .tbl_flat  (tbl)
        );

        lblf_match #(.DEPTH(DEPTH)) u_match (
            .tbl_flat (tbl),
            .label    (label_of(w)),
            .hit      (hit[i])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                acc_stb[i]                   <= 1'b0;
                acc_word[i*WORD_W +: WORD_W] <= '0;
            end else begin
                acc_stb[i] <= rx_valid[i] & ~seq_on & (~flt_en[i] | hit[i]);
                if (rx_valid[i])
                    acc_word[i*WORD_W +: WORD_W] <= w;
            end
        end
    end

    label_t sel_byte;
    logic   any_hit;

    always_comb begin
        sel_byte = '0;
        any_hit  = 1'b0;
        for (int i = 0; i < N_RX; i++) begin
            if (rd_hit[i]) begin
                any_hit  = 1'b1;
                sel_byte = rbyte[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= any_hit;
            if (any_hit)
                rd_data <= sel_byte;
        end
    end

endmodule

// File: rtl/lblf_chk.sv
module lblf_chk #(
    parameter int N_RX = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            seq_on,
    input logic [N_RX-1:0] flt_en,
    input logic [N_RX-1:0] lbl_rd,
    input logic            rd_valid,
    input logic [N_RX-1:0] rx_valid,
    input logic [N_RX-1:0] acc_stb
);

    // R4 / R5: read data only follows a read strobe inside a sequence
    a_r4_rd_after_strobe: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ($past(|lbl_rd) && $past(seq_on)));

    // R5: no read-back outside a sequence
    a_r5_idle_no_read: assert property (@(posedge clk) disable iff (rst)
        !seq_on |=> !rd_valid);

    // R6: reception suspended during a sequence
    a_r6_suspend: assert property (@(posedge clk) disable iff (rst)
        seq_on |=> (acc_stb == '0));

    for (genvar i = 0; i < N_RX; i++) begin : g_chk
        // R7: filter off passes every word
        a_r7_pass_all: assert property (@(posedge clk) disable iff (rst)
            (rx_valid[i] && !seq_on && !flt_en[i]) |=> acc_stb[i]);

        // R8: acceptance only for an offered word
        a_r8_acc_has_src: assert property (@(posedge clk) disable iff (rst)
            acc_stb[i] |-> $past(rx_valid[i]));
    end

endmodule

bind label_filter_top lblf_chk #(.N_RX(N_RX)) u_lblf_chk (
    .clk      (clk),
    .rst      (rst),
    .seq_on   (seq_on),
    .flt_en   (flt_en),
    .lbl_rd   (lbl_rd),
    .rd_valid (rd_valid),
    .rx_valid (rx_valid),
    .acc_stb  (acc_stb)
);

// File: tb/test_label_filter_top.sv
module test_label_filter_top;

    localparam int CLK_PERIOD = 10;
    localparam int N_RX  = 2;
    localparam int DEPTH = 16;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  ctl_we = 1'b0;
    logic [N_RX:0]         ctl_wdata = '0;
    logic [7:0]            host_wdata = '0;
    logic [N_RX-1:0]       lbl_wr = '0;
    logic [N_RX-1:0]       lbl_rd = '0;
    logic                  rd_valid;
    logic [7:0]            rd_data;
    logic [N_RX-1:0]       rx_valid = '0;
    logic [N_RX-1:0][31:0] rx_word = '0;
    logic [N_RX-1:0]       acc_stb;
    logic [N_RX*32-1:0]    acc_word;

    always #(CLK_PERIOD/2) clk = ~clk;

    label_filter_top #(.N_RX(N_RX), .DEPTH(DEPTH)) i_label_filter_top (
        .clk        (clk),
        .rst        (rst),
        .ctl_we     (ctl_we),
        .ctl_wdata  (ctl_wdata),
        .host_wdata (host_wdata),
        .lbl_wr     (lbl_wr),
        .lbl_rd     (lbl_rd),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .rx_valid   (rx_valid),
        .rx_word    (rx_word),
        .acc_stb    (acc_stb),
        .acc_word   (acc_word)
    );

    int nchk = 0;
    int nerr = 0;

    // reference model
    logic [7:0]  mdl_mem [N_RX][DEPTH];
    int          mdl_ptr [N_RX];
    logic        mdl_arm = 1'b0;
    logic [1:0]  mdl_flt = '0;

    // scoreboard queues
    logic [31:0] accq0 [$];
    logic [31:0] accq1 [$];
    logic [7:0]  rdq   [$];

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (acc_stb[0]) begin
                if (accq0.size() == 0) chk(1'b0, "R6/R8 unexpected acc rx0", acc_word[31:0], 32'h0);
                else begin
                    logic [31:0] e0;
                    e0 = accq0.pop_front();
                    chk(acc_word[31:0] == e0, "R7/R8 acc word rx0", acc_word[31:0], e0);
                end
            end
            if (acc_stb[1]) begin
                if (accq1.size() == 0) chk(1'b0, "R6/R8/R10 unexpected acc rx1", acc_word[63:32], 32'h0);
                else begin
                    logic [31:0] e1;
                    e1 = accq1.pop_front();
                    chk(acc_word[63:32] == e1, "R7/R8 acc word rx1", acc_word[63:32], e1);
                end
            end
            if (rd_valid) begin
                if (rdq.size() == 0) chk(1'b0, "R4/R5/R11 unexpected read", {24'h0, rd_data}, 32'h0);
                else begin
                    logic [7:0] er;
                    er = rdq.pop_front();
                    chk(rd_data == er, "R4 read data", {24'h0, rd_data}, {24'h0, er});
                end
            end
        end
    end

    task automatic host_ctl(input logic [2:0] v);
        if (v[0] && !mdl_arm) for (int i = 0; i < N_RX; i++) mdl_ptr[i] = 0;
        mdl_arm = v[0];
        mdl_flt = v[2:1];
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic drive(input logic [1:0] wr, input logic [1:0] rd, input logic [7:0] d);
        // model: write wins on a receiver, lowest-index read served
        logic [1:0] g;
        g = rd & (~rd + 2'd1);
        for (int i = 0; i < N_RX; i++) begin
            if (mdl_arm && mdl_ptr[i] < DEPTH) begin
                if (wr[i]) begin
                    mdl_mem[i][mdl_ptr[i]] = d;
                    mdl_ptr[i]++;
                end else if (g[i]) begin
                    rdq.push_back(mdl_mem[i][mdl_ptr[i]]);
                    mdl_ptr[i]++;
                end
            end
        end
        @(negedge clk);
        lbl_wr = wr; lbl_rd = rd; host_wdata = d;
        @(negedge clk);
        lbl_wr = '0; lbl_rd = '0;
    endtask

    function automatic logic mdl_hit(input int rx, input logic [7:0] l);
        for (int k = 0; k < DEPTH; k++) if (mdl_mem[rx][k] == l) return 1'b1;
        return 1'b0;
    endfunction

    task automatic send(input int rx, input logic [31:0] w);
        if (!mdl_arm && (!mdl_flt[rx] || mdl_hit(rx, w[7:0]))) begin
            if (rx == 0) accq0.push_back(w); else accq1.push_back(w);
        end
        @(negedge clk);
        rx_valid[rx] = 1'b1; rx_word[rx] = w;
        @(negedge clk);
        rx_valid = '0;
    endtask

    task automatic drain(input string tag);
        repeat (3) @(negedge clk);
        chk(accq0.size() == 0, tag, accq0.size(), 0);
        chk(accq1.size() == 0, tag, accq1.size(), 0);
        chk(rdq.size() == 0, tag, rdq.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        for (int i = 0; i < N_RX; i++) begin
            mdl_ptr[i] = 0;
            for (int k = 0; k < DEPTH; k++) mdl_mem[i][k] = 8'h00;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset outputs
        chk(rd_valid == 1'b0, "R1 rd_valid after reset", rd_valid, 0);
        chk(acc_stb == '0, "R1 acc_stb after reset", acc_stb, 0);

        // R1 / R9: reset table is all 0x00, label 0x00 matches
        host_ctl(3'b110);
        send(0, 32'hDEAD_BE00);
        send(0, 32'hDEAD_BE05);
        send(1, 32'h1234_5600);
        drain("R1/R9 reset table filter");

        // R5: strobes outside a sequence ignored
        drive(2'b01, 2'b00, 8'h33);
        drive(2'b00, 2'b11, 8'h00);
        send(0, 32'h0000_0033);
        drain("R5 idle strobes ignored");

        // R2/R3: load both tables, 17th load ignored
        host_ctl(3'b001);
        for (int k = 0; k < DEPTH; k++) begin
            drive(2'b01, 2'b00, 8'(k * 8'h11));
            drive(2'b10, 2'b00, 8'(8'h80 + k));
        end
        drive(2'b01, 2'b00, 8'h5A);
        // R6: suspended reception
        send(0, 32'h0000_0011);
        send(1, 32'h0000_0081);
        drain("R3/R6 load and suspend");

        // R2/R4: restart and read rx0 back, mid-run re-arm does not reset
        host_ctl(3'b000);
        host_ctl(3'b001);
        for (int k = 0; k < 4; k++) drive(2'b00, 2'b01, 8'h00);
        host_ctl(3'b001);
        for (int k = 4; k < DEPTH; k++) drive(2'b00, 2'b01, 8'h00);
        drive(2'b00, 2'b01, 8'h00);
        drain("R2/R4 read back rx0");

        // R4/R10: read rx1 back
        host_ctl(3'b000);
        host_ctl(3'b001);
        for (int k = 0; k < DEPTH; k++) drive(2'b00, 2'b10, 8'h00);
        drain("R4/R10 read back rx1");

        // R8/R9: filtering on both receivers
        host_ctl(3'b110);
        send(0, 32'hFFFF_FF00);
        send(0, 32'h1234_56EE);
        send(0, 32'h0000_005A);
        send(0, 32'h0000_0080);
        send(1, 32'hABCD_EF8F);
        send(1, 32'h0000_0011);
        send(1, 32'h0000_0090);
        drain("R8/R9 filtered acceptance");

        // R7/R10: filter only on rx0
        host_ctl(3'b010);
        send(0, 32'h0000_0001);
        send(1, 32'h0000_0001);
        send(1, 32'h5555_5533);
        drain("R7/R10 per-receiver enable");

        // R11: load beats read on one receiver, lowest-index read wins
        host_ctl(3'b000);
        host_ctl(3'b001);
        drive(2'b10, 2'b10, 8'h77);
        drive(2'b00, 2'b11, 8'h00);
        drive(2'b00, 2'b10, 8'h00);
        host_ctl(3'b000);
        host_ctl(3'b001);
        drive(2'b00, 2'b10, 8'h00);
        drain("R11 access priority");
        host_ctl(3'b000);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule